// File: doc/BRIEF.md
# LUT-Driven Brightness Ramp Sequencer

This block plays brightness patterns for a group of PWM channels. A small internal table holds 9-bit brightness entries. Each channel has its own window into that table, given by a low and a high index. At a fixed pace the channel walks through its window and presents the current entry as its duty value. The pace is counted in pulses of a 1 ms tick input. A channel can walk up or down the window, bounce between the two ends, dwell at either end, and either stop after one pass or run without end. A single write to the start register launches any subset of channels on the same clock edge, so that the colours of a multi-channel LED stay in step.

All configuration goes through one write-only register port. The address space has three regions: per-channel fields, table entries and the start mask. Each channel's duty output is a level stream qualified by its valid bit. There is no ready signal and no back-pressure. The consumer, usually a PWM comparator, may sample the duty value on any cycle. The value changes only on the cycle after a tick or after a register write.

Top module: `lut_ramp_seq`

## Requirements
- R1: After reset every `duty_valid_o` bit is 0 and every channel's duty value is 0. A channel whose valid bit is 0 always outputs duty 0.
- R2: A write to address `8'b10xx_xxxx` stores `cfg_wdata_i[8:0]` into table entry `cfg_addr_i[5:0]`. Entries at or above LUT_DEPTH are ignored. The first entry of a new value appears at the duty output of every running channel showing that entry on the next cycle.
- R3: A write to an address of the form `8'b11xx_xxxx` starts every channel c whose bit `cfg_wdata_i[c]` is 1 and whose low and high indices differ. All such channels start on the same edge. On the next cycle each of them has valid 1 and shows its first entry. The first entry is the low index when mode bit 4 is 1, and the high index otherwise.
- R4: Each entry is shown for exactly `step` ticks. A step value of 0 behaves as 1. Channel fields sit at `{1'b0, chan[3:0], field[2:0]}` with these field codes: 0 mode, 1 low index, 2 high index, 3 step, 4 high-end dwell, 5 low-end dwell.
- R5: Mode bit 4 selects the direction. When it is 1 the walk goes from low to high; when it is 0 the walk goes from high to low.
- R6: With mode bit 2 (ping-pong) set, the walk goes to the far end, dwells there, turns and walks back, then dwells at the start end. Each end entry is shown once per visit.
- R7: On reaching the high end, an extra `hdwell × step` ticks are spent there when mode bit 1 is 1. On reaching the low end, an extra `ldwell × step` ticks are spent there when mode bit 0 is 1. A dwell count of 0 adds nothing.
- R8: With mode bit 3 (repeat) set and ping-pong clear, the walk jumps back to the first entry after the far end and its dwell. With both set, the bounce continues without end.
- R9: With mode bit 3 clear, one pass is made and the final entry is then held with valid 1. Without ping-pong the held entry is the far end; with ping-pong it is the start end, after its dwell.
- R10: A start of a channel whose low and high indices are equal puts it idle. Valid becomes 0 and duty becomes 0.
- R11: Without a tick or a register write, no duty output and no table position changes.
- R12: A start write leaves every channel whose mask bit is 0 exactly as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register address |
| cfg_wdata_i | input | 9 | Register write data |
| duty_o | output | NCH*DUTY_W | Duty value per channel, channel 0 in the low bits |
| duty_valid_o | output | NCH | Channel is running or holding its final entry |

## Verification
The bound checker checks four things on every cycle. The duty bus and each channel's table position stay still unless a tick or write arrives. A valid bit rises only after a start write that has that channel's mask bit set. A valid bit falls only after such a write. The actual ordering of entries cannot be seen by a per-cycle property. This covers reversal, bounce turns, dwell lengths, wrap-around and the one-shot hold, and only the bench's scenarios show it. The bench compares the shown entry after a chosen number of ticks against a walk built from the requirements.

// File: rtl/lut_ramp_pkg.sv
package lut_ramp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_DWELL,
    ST_HOLD
  } ramp_state_e;

  localparam logic [2:0] FLD_MODE   = 3'd0;
  localparam logic [2:0] FLD_LO     = 3'd1;
  localparam logic [2:0] FLD_HI     = 3'd2;
  localparam logic [2:0] FLD_STEP   = 3'd3;
  localparam logic [2:0] FLD_HDWELL = 3'd4;
  localparam logic [2:0] FLD_LDWELL = 3'd5;

  localparam int MB_LDWELL = 0;
  localparam int MB_HDWELL = 1;
  localparam int MB_BOUNCE = 2;
  localparam int MB_REPEAT = 3;
  localparam int MB_UP     = 4;

  localparam logic [1:0] SPACE_LUT   = 2'b10;
  localparam logic [1:0] SPACE_START = 2'b11;

endpackage

// File: rtl/lut_ramp_table.sv
module lut_ramp_table #(
  parameter int DEPTH  = 32,
  parameter int DUTY_W = 9,
  parameter int IDX_W  = 8,
  parameter int NRD    = 3,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [DUTY_W-1:0]     wdata,
  input  logic [NRD*IDX_W-1:0]  ridx,
  output logic [NRD*DUTY_W-1:0] rdata
);

  logic [DUTY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx = ridx[r*IDX_W +: IDX_W];
    assign rdata[r*DUTY_W +: DUTY_W] =
      ({1'b0, idx} < (IDX_W+1)'(DEPTH)) ? mem_q[idx[AW-1:0]] : '0;
  end

endmodule

// File: rtl/lut_ramp_chan.sv
module lut_ramp_chan
  import lut_ramp_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int STEP_W  = 9,
  parameter int DWELL_W = 8,
  parameter int DUTY_W  = 9,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        wr_field,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [DUTY_W-1:0] entry,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              valid_o
);

  logic [4:0]         mode_q;
  logic [IDX_W-1:0]   lo_q, hi_q;
  logic [STEP_W-1:0]  step_q;
  logic [DWELL_W-1:0] hdw_q, ldw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      step_q <= '0;
      hdw_q  <= '0;
      ldw_q  <= '0;
    end else if (wr_en) begin
      case (wr_field)
        FLD_MODE:   mode_q <= wr_data[4:0];
        FLD_LO:     lo_q   <= wr_data[IDX_W-1:0];
        FLD_HI:     hi_q   <= wr_data[IDX_W-1:0];
        FLD_STEP:   step_q <= wr_data[STEP_W-1:0];
        FLD_HDWELL: hdw_q  <= wr_data[DWELL_W-1:0];
        FLD_LDWELL: ldw_q  <= wr_data[DWELL_W-1:0];
        default: ;
      endcase
    end
  end

  ramp_state_e        st_q;
  logic [IDX_W-1:0]   idx_q;
  logic               up_q;
  logic [STEP_W-1:0]  tcnt_q;
  logic [DWELL_W-1:0] dcnt_q;

  logic               step_done, at_end, at_start_end;
  logic [DWELL_W-1:0] end_dwell;
  logic [IDX_W-1:0]   first_idx;
  ramp_state_e        leave_st;
  logic [IDX_W-1:0]   leave_idx;
  logic               leave_up;

  assign step_done    = (step_q == '0) || (tcnt_q == step_q - 1'b1);
  assign at_end       = up_q ? (idx_q == hi_q) : (idx_q == lo_q);
  assign at_start_end = (up_q != mode_q[MB_UP]);
  assign first_idx    = mode_q[MB_UP] ? lo_q : hi_q;
  assign end_dwell    = up_q ? (mode_q[MB_HDWELL] ? hdw_q : '0)
                             : (mode_q[MB_LDWELL] ? ldw_q : '0);

  // Where the walk goes once an end entry and its dwell are finished.
  always_comb begin
    leave_st  = ST_STEP;
    leave_idx = idx_q;
    leave_up  = up_q;
    if (mode_q[MB_BOUNCE]) begin
      if (at_start_end && !mode_q[MB_REPEAT]) begin
        leave_st = ST_HOLD;
      end else begin
        leave_up  = !up_q;
        leave_idx = up_q ? idx_q - 1'b1 : idx_q + 1'b1;
      end
    end else if (mode_q[MB_REPEAT]) begin
      leave_idx = first_idx;
      leave_up  = mode_q[MB_UP];
    end else begin
      leave_st = ST_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      up_q   <= 1'b1;
      tcnt_q <= '0;
      dcnt_q <= '0;
    end else if (start) begin
      tcnt_q <= '0;
      dcnt_q <= '0;
      if (lo_q != hi_q) begin
        st_q  <= ST_STEP;
        idx_q <= first_idx;
        up_q  <= mode_q[MB_UP];
      end else begin
        st_q <= ST_IDLE;
      end
    end else if (tick) begin
      case (st_q)
        ST_STEP: begin
          if (!step_done) begin
            tcnt_q <= tcnt_q + 1'b1;
          end else begin
            tcnt_q <= '0;
            if (!at_end) begin
              idx_q <= up_q ? idx_q + 1'b1 : idx_q - 1'b1;
            end else if (end_dwell != '0) begin
              st_q   <= ST_DWELL;
              dcnt_q <= '0;
            end else begin
              st_q  <= leave_st;
              idx_q <= leave_idx;
              up_q  <= leave_up;
            end
          end
        end
        ST_DWELL: begin
          if (!step_done) begin
            tcnt_q <= tcnt_q + 1'b1;
          end else begin
            tcnt_q <= '0;
            if (dcnt_q == end_dwell - 1'b1) begin
              st_q  <= leave_st;
              idx_q <= leave_idx;
              up_q  <= leave_up;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign valid_o = (st_q != ST_IDLE);
  assign duty_o  = valid_o ? entry : '0;
  assign idx_o   = idx_q;

endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
  import lut_ramp_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int LUT_DEPTH = 32,
  parameter int DUTY_W    = 9,
  parameter int IDX_W     = 8,
  parameter int STEP_W    = 9,
  parameter int DWELL_W   = 8,
  localparam int DATA_W   = (STEP_W > DUTY_W) ? STEP_W : DUTY_W,
  localparam int LUT_AW   = (LUT_DEPTH > 1) ? $clog2(LUT_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  cfg_we_i,
  input  logic [7:0]            cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  output logic [NCH*DUTY_W-1:0] duty_o,
  output logic [NCH-1:0]        duty_valid_o
);

  logic                  chan_space, lut_we, start_hit;
  logic [3:0]            chan_num;
  logic [NCH*IDX_W-1:0]  cur_idx;
  logic [NCH*DUTY_W-1:0] entries;

  assign chan_space = cfg_we_i && !cfg_addr_i[7];
  assign chan_num   = cfg_addr_i[6:3];
  assign start_hit  = cfg_we_i && (cfg_addr_i[7:6] == SPACE_START);
  assign lut_we     = cfg_we_i && (cfg_addr_i[7:6] == SPACE_LUT) &&
                      ({1'b0, cfg_addr_i[5:0]} < 7'(LUT_DEPTH));

  lut_ramp_table #(
    .DEPTH (LUT_DEPTH),
    .DUTY_W(DUTY_W),
    .IDX_W (IDX_W),
    .NRD   (NCH)
  ) u_table (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (lut_we),
    .waddr(cfg_addr_i[LUT_AW-1:0]),
    .wdata(cfg_wdata_i[DUTY_W-1:0]),
    .ridx (cur_idx),
    .rdata(entries)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic wr_en, start;
    assign wr_en = chan_space && (chan_num == 4'(c));
    assign start = start_hit && cfg_wdata_i[c];

    lut_ramp_chan #(
      .IDX_W  (IDX_W),
      .STEP_W (STEP_W),
      .DWELL_W(DWELL_W),
      .DUTY_W (DUTY_W),
      .DATA_W (DATA_W)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i),
      .wr_en   (wr_en),
      .wr_field(cfg_addr_i[2:0]),
      .wr_data (cfg_wdata_i),
      .start   (start),
      .entry   (entries[c*DUTY_W +: DUTY_W]),
      .idx_o   (cur_idx[c*IDX_W +: IDX_W]),
      .duty_o  (duty_o[c*DUTY_W +: DUTY_W]),
      .valid_o (duty_valid_o[c])
    );
  end

endmodule

// File: rtl/lut_ramp_seq_chk.sv
module lut_ramp_seq_chk #(
  parameter int NCH    = 3,
  parameter int DUTY_W = 9,
  parameter int IDX_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  cfg_we,
  input logic [1:0]            cfg_space,
  input logic [NCH-1:0]        start_mask,
  input logic [NCH*DUTY_W-1:0] duty,
  input logic [NCH-1:0]        valid,
  input logic [NCH*IDX_W-1:0]  idx
);

  logic start_any;
  assign start_any = cfg_we && (cfg_space == 2'b11);

  // R11: outputs only move after a tick or a write
  a_r11_duty_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we) |=> $stable(duty));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3: a channel becomes valid only through its start bit
    a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid[c]) |-> $past(start_any && start_mask[c]));
    // R10: a channel leaves the valid state only through its start bit
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid[c]) |-> $past(start_any && start_mask[c]));
    // R11: table position moves only on a tick or this channel's start
    a_r11_idx_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(start_any && start_mask[c])) |=> $stable(idx[c*IDX_W +: IDX_W]));
  end

endmodule

bind lut_ramp_seq lut_ramp_seq_chk #(
  .NCH   (NCH),
  .DUTY_W(DUTY_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_i),
  .cfg_we    (cfg_we_i),
  .cfg_space (cfg_addr_i[7:6]),
  .start_mask(cfg_wdata_i[NCH-1:0]),
  .duty      (duty_o),
  .valid     (duty_valid_o),
  .idx       (cur_idx)
);

// File: tb/lut_ramp_seq_test.sv
module lut_ramp_seq_test;

  localparam int NCH = 3;
  localparam int DW  = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [7:0]    cfg_addr_i = '0;
  logic [8:0]    cfg_wdata_i = '0;
  logic [NCH*DW-1:0] duty_o;
  logic [NCH-1:0]    duty_valid_o;

  always #2.5 clk = ~clk;

  lut_ramp_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .duty_o(duty_o), .duty_valid_o(duty_valid_o)
  );

  typedef struct packed {
    logic [4:0]  mode;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [8:0]  step;
    logic [7:0]  hdw;
    logic [7:0]  ldw;
    logic [15:0] n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'b11000, 8'd2, 8'd5, 9'd3, 8'd0, 8'd0, 16'd0,  4'd3},  // R3 first entry
    '{5'b11000, 8'd2, 8'd5, 9'd3, 8'd0, 8'd0, 16'd3,  4'd4},  // R4 advance after step
    '{5'b11000, 8'd2, 8'd5, 9'd3, 8'd0, 8'd0, 16'd2,  4'd4},  // R4 still held
    '{5'b11000, 8'd2, 8'd5, 9'd3, 8'd0, 8'd0, 16'd12, 4'd8},  // R8 wrap
    '{5'b01000, 8'd2, 8'd5, 9'd2, 8'd0, 8'd0, 16'd2,  4'd5},  // R5 reverse
    '{5'b10000, 8'd1, 8'd3, 9'd1, 8'd0, 8'd0, 16'd50, 4'd9},  // R9 one pass
    '{5'b11100, 8'd1, 8'd3, 9'd1, 8'd0, 8'd0, 16'd3,  4'd6},  // R6 turn
    '{5'b11100, 8'd1, 8'd3, 9'd1, 8'd0, 8'd0, 16'd4,  4'd6},  // R6 back at start
    '{5'b11110, 8'd1, 8'd3, 9'd2, 8'd2, 8'd0, 16'd7,  4'd7},  // R7 high dwell
    '{5'b11110, 8'd1, 8'd3, 9'd2, 8'd2, 8'd0, 16'd10, 4'd7},  // R7 after dwell
    '{5'b01001, 8'd0, 8'd2, 9'd1, 8'd0, 8'd1, 16'd4,  4'd7},  // R7 low dwell, R8
    '{5'b10100, 8'd0, 8'd2, 9'd1, 8'd0, 8'd0, 16'd20, 4'd9},  // R9 bounce once
    '{5'b11000, 8'd4, 8'd6, 9'd0, 8'd0, 8'd0, 16'd1,  4'd4},  // R4 step zero
    '{5'b11010, 8'd0, 8'd1, 9'd1, 8'd0, 8'd0, 16'd2,  4'd7}   // R7 zero count
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [8:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic set_chan(input int c, input vec_t v);
    wr({1'b0, 4'(c), 3'd0}, {4'd0, v.mode});
    wr({1'b0, 4'(c), 3'd1}, {1'b0, v.lo});
    wr({1'b0, 4'(c), 3'd2}, {1'b0, v.hi});
    wr({1'b0, 4'(c), 3'd3}, v.step);
    wr({1'b0, 4'(c), 3'd4}, {1'b0, v.hdw});
    wr({1'b0, 4'(c), 3'd5}, {1'b0, v.ldw});
  endtask

  function automatic int lut_val(input int i);
    return i * 10 + 3;
  endfunction

  function automatic int duty_of(input int c);
    return int'(duty_o[c*DW +: DW]);
  endfunction

  // Entry shown after v.n ticks, built from the walk the requirements describe.
  function automatic int model_idx(input vec_t v);
    int s, rem, st, far, d, hdc, ldc, farp, stp, i, b, dur;
    s    = (v.step == 0) ? 1 : int'(v.step);
    st   = v.mode[4] ? int'(v.lo) : int'(v.hi);
    far  = v.mode[4] ? int'(v.hi) : int'(v.lo);
    d    = v.mode[4] ? 1 : -1;
    hdc  = v.mode[1] ? int'(v.hdw) : 0;
    ldc  = v.mode[0] ? int'(v.ldw) : 0;
    farp = v.mode[4] ? hdc : ldc;
    stp  = v.mode[4] ? ldc : hdc;
    rem  = int'(v.n);
    b    = st;
    for (int g = 0; g < 1000; g++) begin
      i = b;
      for (int h = 0; h < 300; h++) begin
        dur = s + ((i == far) ? farp * s : 0);
        if (rem < dur) return i;
        rem -= dur;
        if (i == far) break;
        i += d;
      end
      if (!v.mode[2]) begin
        if (!v.mode[3]) return far;
        b = st;
        continue;
      end
      i = far - d;
      for (int h = 0; h < 300; h++) begin
        dur = s + ((i == st) ? stp * s : 0);
        if (rem < dur) return i;
        rem -= dur;
        if (i == st) break;
        i -= d;
      end
      if (!v.mode[3]) return st;
      b = st + d;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid after reset", int'(duty_valid_o), 0);
    check("R1 duty after reset", int'(duty_o), 0);

    // R2 table fill through the register port
    for (int i = 0; i < 32; i++) wr(8'h80 | 8'(i), 9'(lut_val(i)));

    for (int t = 0; t < NV; t++) begin
      set_chan(0, VECS[t]);
      wr(8'hC0, 9'b001);
      ticks(int'(VECS[t].n));
      check($sformatf("R%0d vec %0d duty", VECS[t].req, t), duty_of(0),
            lut_val(model_idx(VECS[t])));
      check($sformatf("R%0d vec %0d valid", VECS[t].req, t), int'(duty_valid_o[0]), 1);
    end

    // R2: rewriting the shown entry (channel 0 holds index 0) updates duty
    wr(8'h80, 9'd427);
    check("R2 live table update", duty_of(0), 427);

    // R3 and R12: start channels 1 and 2 together, channel 0 untouched
    held = duty_of(0);
    v = '{5'b11000, 8'd5, 8'd7, 9'd1, 8'd0, 8'd0, 16'd0, 4'd3};
    set_chan(1, v);
    v = '{5'b01000, 8'd8, 8'd10, 9'd1, 8'd0, 8'd0, 16'd0, 4'd3};
    set_chan(2, v);
    wr(8'hC0, 9'b110);
    check("R3 ch1 valid", int'(duty_valid_o[1]), 1);
    check("R3 ch2 valid", int'(duty_valid_o[2]), 1);
    check("R3 ch1 first entry", duty_of(1), lut_val(5));
    check("R3 ch2 first entry", duty_of(2), lut_val(10));
    check("R12 ch0 duty kept", duty_of(0), held);
    check("R12 ch0 valid kept", int'(duty_valid_o[0]), 1);
    ticks(1);
    check("R3 ch1 same pace", duty_of(1), lut_val(6));
    check("R3 ch2 same pace", duty_of(2), lut_val(9));

    // R11: no tick, no write -> nothing moves
    repeat (6) @(negedge clk);
    check("R11 ch1 steady", duty_of(1), lut_val(6));
    check("R11 ch2 steady", duty_of(2), lut_val(9));

    // R10: equal indices put the channel idle
    wr({1'b0, 4'd2, 3'd1}, 9'd4);
    wr({1'b0, 4'd2, 3'd2}, 9'd4);
    wr(8'hC0, 9'b100);
    check("R10 ch2 valid low", int'(duty_valid_o[2]), 0);
    check("R10 ch2 duty zero", duty_of(2), 0);
    check("R12 ch1 still runs", duty_of(1), lut_val(6));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule